// File: doc/BRIEF.md
# Inverter Gate Protection Fault Controller

This block sits between six high-active PWM gate commands and the six gate enables of a three-phase bridge. It has three high-side legs and three low-side legs. It passes each command to its gate once the command has been stable long enough to count as real. It blocks gates when a protection input fires, and it drives an active-low, open-drain style fault line. Every protection input is a digital comparator output that is already synchronised to the clock. An internal divider makes a microsecond tick, and the fault-width timer counts that tick.

Each fault class has its own rule:
- A low-side short-circuit event turns off every low-side gate and produces a fault pulse of fixed minimum width.
- Low-side supply under-voltage and over-temperature hold the low-side gates off and keep the fault line asserted for as long as the flag is active, with the same minimum width.
- A high-side supply under-voltage flag blocks only its own leg, and it raises no fault.

After any block, a gate does not turn on from a command that is already high. It waits for the next fresh rising edge of that command.

Top module: `gate_guard`

## Requirements
- R1: While reset is asserted, every gate enable is low and `fault_n_o` is high. After reset, a gate turns on only after a rising edge of its filtered command.
- R2: A command change that lasts fewer than `FILT_CYC` clock cycles, high or low, never reaches the gate enable. The default of 63 cycles is about 0.5 µs at 125 MHz.
- R3: An armed gate follows its command. It turns on `FILT_CYC`+1 cycles after a stable change.
- R4: A short-circuit input forces all three low-side gates low from the next cycle. It also pulls `fault_n_o` low for at least `FAULT_TICKS` ticks and for no more than one extra tick plus a cycle.
- R5: After a short circuit, a low-side gate whose command stayed high remains off. It turns on again only after the command goes low and then high.
- R6: While `uv_lo_i` is high, all low-side gates are low and `fault_n_o` is low. A one-cycle flag still gives a fault pulse of at least `FAULT_TICKS` ticks.
- R7: When a low-side under-voltage or over-temperature flag clears, low-side gates whose command is still high stay off until the next rising edge of the command.
- R8: While `ot_i` is high, all low-side gates are low and `fault_n_o` is low, with the same minimum width as R6.
- R9: A high `uv_hi_i[k]` forces only `gate_hi_o[k]` low. It leaves `fault_n_o` high, and after it clears the gate waits for a fresh rising edge.
- R10: A new short-circuit event while the fault pulse is running restarts the minimum-width timer.
- R11: When fault sources overlap, `fault_n_o` stays low while any level flag or any running timer asks for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_hi_i | input | 3 | High-side PWM commands, one per leg, high-active |
| cmd_lo_i | input | 3 | Low-side PWM commands, one per leg, high-active |
| sc_i | input | 1 | Low-side short-circuit comparator event |
| uv_lo_i | input | 1 | Low-side control supply under-voltage flag |
| uv_hi_i | input | 3 | Per-leg high-side supply under-voltage flags |
| ot_i | input | 1 | Over-temperature flag |
| gate_hi_o | output | 3 | High-side gate enables |
| gate_lo_o | output | 3 | Low-side gate enables |
| fault_n_o | output | 1 | Fault line, active low (pull-down) |

## Verification
The bench goes after the re-arm rule. A design that turned a gate back on when a fault cleared with the command still high would switch on after a short circuit, an under-voltage or an over-temperature event. The bench measures fault pulse widths for one-cycle short-circuit and under-voltage events and for a retrigger in the middle of a pulse. A design that did not guarantee the minimum width, or that ignored the retrigger, would release the fault line early. Glitches one cycle shorter than the filter window are applied in both polarities, and a filter that was off by one would let them through or chop a gate. A high-side under-voltage check and an overlap case with over-temperature plus a late short circuit expose a leaky fault OR or cross-leg blocking.

// File: rtl/gg_pkg.sv
package gg_pkg;
  localparam int unsigned LEGS = 3;
  typedef logic [LEGS-1:0] leg_vec_t;
endpackage

// File: rtl/gg_tick_div.sv
module gg_tick_div #(
  parameter int unsigned CYC_PER_TICK = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(CYC_PER_TICK + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/gg_glitch_filt.sv
module gg_glitch_filt #(
  parameter int unsigned FILT_CYC = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  // output follows raw only after FILT_CYC consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (raw_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      lvl_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = lvl_q;
endmodule

// File: rtl/gg_arm_gate.sv
module gg_arm_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic block_i,
  output logic gate_o
);
  logic cmd_q, armed_q, gate_q;
  logic armed_d;

  // block disarms; only a fresh rising edge while unblocked re-arms
  always_comb begin
    if (block_i)              armed_d = 1'b0;
    else if (cmd_i && !cmd_q) armed_d = 1'b1;
    else                      armed_d = armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= 1'b0;
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      cmd_q   <= cmd_i;
      armed_q <= armed_d;
      gate_q  <= armed_d & cmd_i & ~block_i;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/gg_fault_timer.sv
module gg_fault_timer #(
  parameter int unsigned FAULT_TICKS = 20,
  parameter int unsigned N_LVL       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [N_LVL-1:0] lvl_i,
  output logic             fault_o
);
  localparam int unsigned CW = $clog2(FAULT_TICKS + 2);
  // one extra tick covers the phase of the free-running divider
  localparam logic [CW-1:0] LOAD = CW'(FAULT_TICKS + 1);

  logic [N_LVL-1:0] lvl_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             fault_q;
  logic             start;

  assign start = trig_i | (|(lvl_i & ~lvl_q));

  always_comb begin
    if (start)                       cnt_d = LOAD;
    else if (tick_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_i;
      cnt_q   <= cnt_d;
      fault_q <= trig_i | (|lvl_i) | (cnt_d != '0);
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/gate_guard.sv
module gate_guard
  import gg_pkg::*;
#(
  parameter int unsigned CYC_PER_TICK = 125,
  parameter int unsigned FAULT_TICKS  = 20,
  parameter int unsigned FILT_CYC     = 63
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [LEGS-1:0] cmd_hi_i,
  input  logic [LEGS-1:0] cmd_lo_i,
  input  logic            sc_i,
  input  logic            uv_lo_i,
  input  logic [LEGS-1:0] uv_hi_i,
  input  logic            ot_i,
  output logic [LEGS-1:0] gate_hi_o,
  output logic [LEGS-1:0] gate_lo_o,
  output logic            fault_n_o
);
  logic     tick;
  leg_vec_t cmd_hi_f, cmd_lo_f;
  logic     blk_lo;
  logic     fault;

  assign blk_lo = sc_i | uv_lo_i | ot_i;

  gg_tick_div #(.CYC_PER_TICK(CYC_PER_TICK)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    gg_glitch_filt #(.FILT_CYC(FILT_CYC)) u_filt_hi (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (cmd_hi_i[g]),
      .filt_o(cmd_hi_f[g])
    );
    gg_glitch_filt #(.FILT_CYC(FILT_CYC)) u_filt_lo (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (cmd_lo_i[g]),
      .filt_o(cmd_lo_f[g])
    );
    gg_arm_gate u_arm_hi (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd_hi_f[g]),
      .block_i(uv_hi_i[g]),
      .gate_o (gate_hi_o[g])
    );
    gg_arm_gate u_arm_lo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd_lo_f[g]),
      .block_i(blk_lo),
      .gate_o (gate_lo_o[g])
    );
  end

  gg_fault_timer #(.FAULT_TICKS(FAULT_TICKS), .N_LVL(2)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .trig_i (sc_i),
    .lvl_i  ({ot_i, uv_lo_i}),
    .fault_o(fault)
  );

  assign fault_n_o = ~fault;
endmodule

// File: rtl/gate_guard_chk.sv
module gate_guard_chk
  import gg_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sc_i,
  input logic            uv_lo_i,
  input logic [LEGS-1:0] uv_hi_i,
  input logic            ot_i,
  input logic [LEGS-1:0] gate_hi_o,
  input logic [LEGS-1:0] gate_lo_o,
  input logic            fault_n_o
);
  assert_reset_safe_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (gate_hi_o == '0 && gate_lo_o == '0 && fault_n_o));

  assert_sc_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_i |=> (gate_lo_o == '0 && !fault_n_o));

  assert_uv_lo_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_lo_i |=> (gate_lo_o == '0 && !fault_n_o));

  assert_ot_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |=> (gate_lo_o == '0 && !fault_n_o));

  for (genvar g = 0; g < LEGS; g++) begin : g_hi
    assert_uv_hi_leg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uv_hi_i[g] |=> !gate_hi_o[g]);
  end
endmodule

bind gate_guard gate_guard_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sc_i     (sc_i),
  .uv_lo_i  (uv_lo_i),
  .uv_hi_i  (uv_hi_i),
  .ot_i     (ot_i),
  .gate_hi_o(gate_hi_o),
  .gate_lo_o(gate_lo_o),
  .fault_n_o(fault_n_o)
);

// File: tb/sim_gate_guard.sv
`timescale 1ns/1ps
module sim_gate_guard;
  localparam int P = 4;   // cycles per tick
  localparam int N = 5;   // fault min ticks
  localparam int F = 3;   // filter cycles
  localparam int W = F + 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_hi_i = '0, cmd_lo_i = '0, uv_hi_i = '0;
  logic       sc_i = 1'b0, uv_lo_i = 1'b0, ot_i = 1'b0;
  logic [2:0] gate_hi_o, gate_lo_o;
  logic       fault_n_o;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  gate_guard #(.CYC_PER_TICK(P), .FAULT_TICKS(N), .FILT_CYC(F)) u0 (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // bench model of the re-arm rule
  function automatic logic [2:0] arm_nxt(logic [2:0] arm, logic [2:0] prev,
                                         logic [2:0] cmd, logic [2:0] clr,
                                         logic [2:0] blk);
    logic [2:0] a;
    a = arm & ~clr;
    for (int b = 0; b < 3; b++) if (!blk[b] && cmd[b] && !prev[b]) a[b] = 1'b1;
    return a;
  endfunction

  function automatic logic [2:0] gate_of(logic [2:0] arm, logic [2:0] cmd,
                                         logic [2:0] blk);
    return arm & cmd & ~blk;
  endfunction

  task automatic sc_width(output int c);
    c = 0;
    sc_i = 1'b1; @(negedge clk_i); sc_i = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (fault_n_o) break;
      c++;
      @(negedge clk_i);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wt(3); rst_ni = 1'b1; wt(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int c;
    bit ok;
    logic [2:0] arm_h, arm_l, prv_h, prv_l, nh, nl, uvh;
    logic uvl, ot, scp;
    int last_src;
    wt(2);
    // R1 reset state
    chk(gate_hi_o == 0 && gate_lo_o == 0, "R1", "gates in reset", {gate_hi_o, gate_lo_o}, 0);
    chk(fault_n_o == 1'b1, "R1", "fault in reset", fault_n_o, 1);
    rst_ni = 1'b1; wt(2);

    // R3 first rising edge after reset arms
    cmd_lo_i = 3'b001; cmd_hi_i = 3'b010; wt(W);
    chk(gate_lo_o == 3'b001, "R3", "gate_lo follows", gate_lo_o, 1);
    chk(gate_hi_o == 3'b010, "R3", "gate_hi follows", gate_hi_o, 2);

    // R2 short high glitch never reaches gate
    ok = 1'b1;
    cmd_lo_i[1] = 1'b1; wt(F - 1); cmd_lo_i[1] = 1'b0;
    for (int k = 0; k < 10; k++) begin if (gate_lo_o[1]) ok = 1'b0; wt(1); end
    chk(ok, "R2", "high glitch passed", !ok, 0);
    // R2 short low glitch does not chop gate
    ok = 1'b1;
    cmd_lo_i[0] = 1'b0; wt(F - 1); cmd_lo_i[0] = 1'b1;
    for (int k = 0; k < 10; k++) begin if (!gate_lo_o[0]) ok = 1'b0; wt(1); end
    chk(ok, "R2", "low glitch chopped gate", !ok, 0);

    // R4 short circuit pulse width and block
    cmd_lo_i = 3'b011; wt(W);
    chk(gate_lo_o == 3'b011, "R3", "second leg armed", gate_lo_o, 3);
    sc_width(c);
    chk(c >= N * P && c <= (N + 1) * P + 1, "R4", "sc pulse width", c, N * P);
    chk(gate_lo_o == 3'b000, "R4", "low gates off after sc", gate_lo_o, 0);
    wt(W);
    chk(gate_lo_o == 3'b000, "R5", "held cmd no re-arm", gate_lo_o, 0);
    chk(gate_hi_o == 3'b010, "R4", "high side untouched", gate_hi_o, 2);
    cmd_lo_i[0] = 1'b0; wt(W); cmd_lo_i[0] = 1'b1; wt(W);
    chk(gate_lo_o == 3'b001, "R5", "re-arm after toggle", gate_lo_o, 1);

    // R10 retrigger during pulse
    c = 0;
    sc_i = 1'b1; @(negedge clk_i); sc_i = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (fault_n_o) break;
      c++;
      if (k == 12) sc_i = 1'b1;
      if (k == 13) sc_i = 1'b0;
      @(negedge clk_i);
    end
    chk(c >= 12 + N * P && c <= 14 + (N + 1) * P, "R10", "retrigger width", c, 13 + N * P);
    cmd_lo_i = 3'b000; wt(W); cmd_lo_i = 3'b001; wt(W);

    // R6 long under-voltage
    ok = 1'b1;
    uv_lo_i = 1'b1; wt(1);
    for (int k = 0; k < 60; k++) begin
      if (fault_n_o || gate_lo_o != 0) ok = 1'b0;
      wt(1);
    end
    chk(ok, "R6", "uv hold gates/fault", !ok, 0);
    uv_lo_i = 1'b0; wt(3);
    chk(fault_n_o == 1'b1, "R6", "fault released after uv", fault_n_o, 1);
    wt(W);
    chk(gate_lo_o == 3'b000, "R7", "no resume from level after uv", gate_lo_o, 0);
    cmd_lo_i[0] = 1'b0; wt(W); cmd_lo_i[0] = 1'b1; wt(W);
    chk(gate_lo_o == 3'b001, "R7", "resume on edge after uv", gate_lo_o, 1);

    // R6 short under-voltage min width
    c = 0;
    uv_lo_i = 1'b1; @(negedge clk_i); uv_lo_i = 1'b0;
    for (int k = 0; k < 400; k++) begin if (fault_n_o) break; c++; @(negedge clk_i); end
    chk(c >= N * P && c <= (N + 1) * P + 1, "R6", "short uv width", c, N * P);
    cmd_lo_i[0] = 1'b0; wt(W); cmd_lo_i[0] = 1'b1; wt(W);

    // R8 over-temperature
    ok = 1'b1;
    ot_i = 1'b1; wt(1);
    for (int k = 0; k < 40; k++) begin
      if (fault_n_o || gate_lo_o != 0) ok = 1'b0;
      wt(1);
    end
    chk(ok, "R8", "ot hold gates/fault", !ok, 0);
    ot_i = 1'b0; wt(W);
    chk(fault_n_o == 1'b1, "R8", "fault released after ot", fault_n_o, 1);
    chk(gate_lo_o == 3'b000, "R7", "no resume from level after ot", gate_lo_o, 0);
    cmd_lo_i[0] = 1'b0; wt(W); cmd_lo_i[0] = 1'b1; wt(W);
    chk(gate_lo_o == 3'b001, "R7", "resume on edge after ot", gate_lo_o, 1);

    // R9 high-side under-voltage
    cmd_hi_i = 3'b000; wt(W); cmd_hi_i = 3'b111; wt(W);
    chk(gate_hi_o == 3'b111, "R3", "all high legs on", gate_hi_o, 7);
    ok = 1'b1;
    uv_hi_i = 3'b010; wt(2);
    for (int k = 0; k < 30; k++) begin
      if (!fault_n_o || gate_hi_o != 3'b101 || gate_lo_o != 3'b001) ok = 1'b0;
      wt(1);
    end
    chk(ok, "R9", "uv_hi blocks one leg silently", !ok, 0);
    uv_hi_i = 3'b000; wt(W);
    chk(gate_hi_o == 3'b101, "R9", "no resume from level", gate_hi_o, 5);
    cmd_hi_i[1] = 1'b0; wt(W); cmd_hi_i[1] = 1'b1; wt(W);
    chk(gate_hi_o == 3'b111, "R9", "resume on edge", gate_hi_o, 7);

    // R11 overlap: ot long, sc near its end
    ot_i = 1'b1; wt(38);
    sc_i = 1'b1; wt(1); sc_i = 1'b0; wt(1);
    ot_i = 1'b0; wt(8);
    chk(fault_n_o == 1'b0, "R11", "sc timer holds after ot clear", fault_n_o, 0);
    wt((N + 1) * P);
    chk(fault_n_o == 1'b1, "R11", "fault released", fault_n_o, 1);
    uv_lo_i = 1'b1; ot_i = 1'b1; wt(30); ot_i = 1'b0; wt(3);
    chk(fault_n_o == 1'b0, "R11", "uv keeps fault after ot drop", fault_n_o, 0);
    uv_lo_i = 1'b0; wt(3);
    chk(fault_n_o == 1'b1, "R11", "both clear", fault_n_o, 1);

    // random phase against the bench model
    cmd_hi_i = '0; cmd_lo_i = '0; uv_hi_i = '0;
    do_reset();
    chk(gate_hi_o == 0 && gate_lo_o == 0 && fault_n_o, "R1", "mid-run reset", {gate_hi_o, gate_lo_o}, 0);
    void'($urandom(32'h5eed_1234));
    arm_h = '0; arm_l = '0; prv_h = '0; prv_l = '0; uvh = '0; uvl = 1'b0; ot = 1'b0;
    last_src = cyc;
    for (int s = 0; s < 400; s++) begin
      scp = ($urandom_range(0, 7) == 0);
      if (scp) begin sc_i = 1'b1; wt(1); sc_i = 1'b0; end
      if (scp || uvl || ot) last_src = cyc;
      nh  = 3'($urandom_range(0, 7));
      nl  = 3'($urandom_range(0, 7));
      uvh = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
      uvl = ($urandom_range(0, 7) == 0);
      ot  = ($urandom_range(0, 7) == 0);
      cmd_hi_i = nh; cmd_lo_i = nl; uv_hi_i = uvh; uv_lo_i = uvl; ot_i = ot;
      arm_h = arm_nxt(arm_h, prv_h, nh, uvh, uvh);
      arm_l = arm_nxt(arm_l, prv_l, nl, {3{scp | uvl | ot}}, {3{uvl | ot}});
      prv_h = nh; prv_l = nl;
      wt($urandom_range(F + 4, F + 40));
      chk(gate_hi_o == gate_of(arm_h, nh, uvh), "R9", "random gate_hi", gate_hi_o, gate_of(arm_h, nh, uvh));
      chk(gate_lo_o == gate_of(arm_l, nl, {3{uvl | ot}}), "R7", "random gate_lo", gate_lo_o,
          gate_of(arm_l, nl, {3{uvl | ot}}));
      if (uvl || ot)
        chk(fault_n_o == 1'b0, "R11", "random fault active", fault_n_o, 0);
      else if (cyc - last_src > (N + 1) * P + 3)
        chk(fault_n_o == 1'b1, "R6", "random fault idle", fault_n_o, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule